// File: doc/BRIEF.md
# Four-Channel PCM Gain and Polarity Stage

This block scales signed 24-bit PCM samples from four channels by a digital gain picked per channel, can reverse the polarity of each channel, and clips the result to the sample range. Each channel holds an 8-bit signed volume code, where one step is half a decibel, and an invert enable. Software loads both through a single-cycle write port that addresses one channel per write.

A sample word holds all four channels and is qualified by a valid bit. It passes through a two-stage pipeline. The first stage forms the full-precision product of the sample and a mantissa taken from the volume code. The second stage applies a power-of-two shift for the whole 6 dB steps, negates the value if invert is set, and saturates it. A channel that clips raises its bit of a one-cycle overflow vector. That bit is aligned with the output sample that clipped.

The gain is built from a mantissa and a shift. Each whole 6 dB step counts as an exact factor of two. The twelve half-decibel steps in between use mantissa constants that are derived at elaboration time.

Top module: `pcm_gain_invert`

## Requirements
- R1: After reset, out_valid and out_ovf are 0. Every channel has volume code 0x00 and invert 0, so a sample then leaves the block unchanged.
- R2: A sample accepted with in_valid high at a clock edge appears two edges later, with out_valid high for exactly one cycle.
- R3: Volume code 0x00 without invert returns the input sample unchanged.
- R4: For a code c read as signed, let h = min(c, 48), q = floor(h/12) and r = h - 12q. The output is floor(x * M[r] * 2^q / 2^16), where M[r] = round(65536 * 10^(r/40)).
- R5: Every code from 0x30 to 0x7F gives the same gain as 0x30, which is a factor of 16 (+24 dB).
- R6: Code 0x80 (-64 dB) is the smallest gain: q = -11 and r = 4 in the R4 formula.
- R7: With invert set, the channel's output is the negation of the gained value. Negation is applied after the gain and before saturation.
- R8: Results above 0x7FFFFF or below -0x800000 are clamped to that limit. The channel's bit k of out_ovf is then 1 in the same cycle as out_valid.
- R9: Inverting -0x800000 at 0 dB gives 0x7FFFFF and raises that channel's overflow bit.
- R10: When cfg_we is high at an edge, the channel selected by cfg_ch loads cfg_vol and cfg_inv. The other channels keep their settings. The change applies to samples accepted at later edges.
- R11: Channel k occupies bits [24k+23:24k] of both in_data and out_data, and bit k of out_ovf.
- R12: out_ovf is all zero in every cycle where out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write enable for one channel's settings |
| cfg_ch | input | 2 | Channel index addressed by the write |
| cfg_vol | input | 8 | Signed half-decibel volume code |
| cfg_inv | input | 1 | Polarity invert enable |
| in_valid | input | 1 | Input sample word valid |
| in_data | input | 96 | Four signed 24-bit input samples |
| out_valid | output | 1 | Output sample word valid |
| out_data | output | 96 | Four signed 24-bit output samples |
| out_ovf | output | 4 | Per-channel clip pulse |

## Verification
The bench builds the block with its default parameters: four channels of 24-bit samples and an 8-bit code. With these values the whole code range can be reached, from the -64 dB floor through the clamp region above +24 dB. Both saturation rails can be driven by real sample values at moderate gains. The negation corner at -0x800000 can be reached directly. Because the channel index is two bits wide, the bench can cycle the vector table over all four lanes and check that a write to one lane leaves the other three untouched.

// File: rtl/pgi_pkg.sv
package pgi_pkg;
    localparam int CODE_W      = 8;
    localparam int MAX_HALF_DB = 48;
    localparam int STEPS       = 12;
    localparam int FRAC        = 16;
    localparam int MW          = FRAC + 1;
    localparam int SH_W        = 5;
    localparam int Q_BIAS      = 11;
    localparam int H_BIAS      = Q_BIAS * STEPS;
    localparam int SH_OFS      = FRAC + Q_BIAS;

    typedef struct packed {
        logic [CODE_W-1:0] vol;
        logic              inv;
    } chan_cfg_t;

    function automatic logic [STEPS*MW-1:0] mant_table();
        logic [STEPS*MW-1:0] tbl;
        tbl = '0;
        for (int r = 0; r < STEPS; r++) begin
            tbl[r*MW +: MW] = MW'($rtoi(65536.0 * (10.0 ** (r / 40.0)) + 0.5));
        end
        return tbl;
    endfunction
endpackage

// File: rtl/pgi_gain_decode.sv
module pgi_gain_decode
    import pgi_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output logic [MW-1:0]     mant,
    output logic [SH_W-1:0]   shamt
);
    localparam logic [STEPS*MW-1:0] MANT_TAB = mant_table();

    logic signed [CODE_W:0] half_db;
    logic        [CODE_W:0] biased;
    logic        [3:0]      q_plus;
    logic        [3:0]      rem;

    always_comb begin
        half_db = $signed({code[CODE_W-1], code});
        if (half_db > (CODE_W+1)'(MAX_HALF_DB)) begin
            half_db = (CODE_W+1)'(MAX_HALF_DB);
        end
        biased = $unsigned(half_db + (CODE_W+1)'(H_BIAS));
        q_plus = 4'(biased / (CODE_W+1)'(STEPS));
        rem    = 4'(biased % (CODE_W+1)'(STEPS));
        mant   = MANT_TAB[rem*MW +: MW];
        shamt  = SH_W'(SH_OFS - int'(q_plus));
    end
endmodule

// File: rtl/pgi_cfg_regs.sv
module pgi_cfg_regs
    import pgi_pkg::*;
#(
    parameter int NCH = 4,
    localparam int CHW = $clog2(NCH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [CHW-1:0]        ch,
    input  logic [CODE_W-1:0]     vol,
    input  logic                  inv,
    output chan_cfg_t [NCH-1:0]   cfg
);
    chan_cfg_t [NCH-1:0] cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            cfg_d[ch].vol = vol;
            cfg_d[ch].inv = inv;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/pgi_lane.sv
module pgi_lane
    import pgi_pkg::*;
#(
    parameter int SW = 24,
    localparam int PW = SW + MW + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 take,
    input  logic                 emit,
    input  logic signed [SW-1:0] x,
    input  logic [MW-1:0]        mant,
    input  logic [SH_W-1:0]      shamt,
    input  logic                 inv,
    output logic signed [SW-1:0] y,
    output logic                 ovf
);
    localparam logic signed [PW-1:0] POS_RAIL = PW'((64'sd1 <<< (SW-1)) - 1);
    localparam logic signed [PW-1:0] NEG_RAIL = -PW'(64'sd1 <<< (SW-1));

    typedef struct packed {
        logic signed [PW-1:0] prod;
        logic [SH_W-1:0]      sh;
        logic                 inv;
        logic signed [SW-1:0] y;
        logic                 ovf;
    } lane_st_t;

    lane_st_t st_d, st_q;
    logic signed [PW-1:0] scaled;
    logic signed [PW-1:0] signed_val;

    always_comb begin
        st_d       = st_q;
        st_d.ovf   = 1'b0;
        scaled     = $signed(st_q.prod) >>> st_q.sh;
        signed_val = st_q.inv ? -scaled : scaled;
        if (take) begin
            st_d.prod = PW'($signed({1'b0, mant}) * x);
            st_d.sh   = shamt;
            st_d.inv  = inv;
        end
        if (emit) begin
            if (signed_val > POS_RAIL) begin
                st_d.y   = POS_RAIL[SW-1:0];
                st_d.ovf = 1'b1;
            end else if (signed_val < NEG_RAIL) begin
                st_d.y   = NEG_RAIL[SW-1:0];
                st_d.ovf = 1'b1;
            end else begin
                st_d.y   = signed_val[SW-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign y   = st_q.y;
    assign ovf = st_q.ovf;
endmodule

// File: rtl/pcm_gain_invert.sv
module pcm_gain_invert
    import pgi_pkg::*;
#(
    parameter int NCH = 4,
    parameter int SW  = 24,
    localparam int CHW = $clog2(NCH),
    localparam int DW  = NCH * SW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CHW-1:0]    cfg_ch,
    input  logic [CODE_W-1:0] cfg_vol,
    input  logic              cfg_inv,
    input  logic              in_valid,
    input  logic [DW-1:0]     in_data,
    output logic              out_valid,
    output logic [DW-1:0]     out_data,
    output logic [NCH-1:0]    out_ovf
);
    typedef struct packed {
        logic v1;
        logic v2;
    } pipe_t;

    pipe_t pipe_d, pipe_q;
    chan_cfg_t [NCH-1:0] cfg;

    always_comb begin
        pipe_d    = pipe_q;
        pipe_d.v1 = in_valid;
        pipe_d.v2 = pipe_q.v1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    pgi_cfg_regs #(.NCH(NCH)) i_regs (
        .clk (clk),
        .rst_n (rst_n),
        .we  (cfg_we),
        .ch  (cfg_ch),
        .vol (cfg_vol),
        .inv (cfg_inv),
        .cfg (cfg)
    );

    for (genvar k = 0; k < NCH; k++) begin : g_lane
        logic [MW-1:0]   mant;
        logic [SH_W-1:0] shamt;
        logic [SW-1:0]   y;

        pgi_gain_decode i_dec (
            .code  (cfg[k].vol),
            .mant  (mant),
            .shamt (shamt)
        );

        pgi_lane #(.SW(SW)) i_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .take  (in_valid),
            .emit  (pipe_q.v1),
            .x     ($signed(in_data[k*SW +: SW])),
            .mant  (mant),
            .shamt (shamt),
            .inv   (cfg[k].inv),
            .y     (y),
            .ovf   (out_ovf[k])
        );

        assign out_data[k*SW +: SW] = y;
    end

    assign out_valid = pipe_q.v2;
endmodule

// File: rtl/pcm_gain_invert_chk.sv
module pcm_gain_invert_chk #(
    parameter int NCH = 4,
    parameter int SW  = 24,
    localparam int CHW = $clog2(NCH),
    localparam int DW  = NCH * SW
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cfg_we,
    input logic [CHW-1:0] cfg_ch,
    input logic [7:0]     cfg_vol,
    input logic           cfg_inv,
    input logic           in_valid,
    input logic [DW-1:0]  in_data,
    input logic           out_valid,
    input logic [DW-1:0]  out_data,
    input logic [NCH-1:0] out_ovf
);
    logic [1:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            age_q <= '0;
        else if (age_q != 2'd2) age_q <= age_q + 2'd1;
    end

    a_r2_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2) |-> (out_valid == $past(in_valid, 2)));

    a_r12_ovf_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_ovf == '0));

    for (genvar k = 0; k < NCH; k++) begin : g_chk
        a_r8_ovf_at_rail: assert property (@(posedge clk) disable iff (!rst_n)
            out_ovf[k] |-> (out_data[k*SW +: SW] == {1'b0, {(SW-1){1'b1}}}
                         || out_data[k*SW +: SW] == {1'b1, {(SW-1){1'b0}}}));

        a_r4_zero_stays_zero: assert property (@(posedge clk) disable iff (!rst_n)
            ((age_q == 2'd2) && $past(in_valid, 2) && ($past(in_data[k*SW +: SW], 2) == '0))
            |-> (out_data[k*SW +: SW] == '0 && !out_ovf[k]));
    end
endmodule

bind pcm_gain_invert pcm_gain_invert_chk #(.NCH(NCH), .SW(SW)) i_chk (.*);

// File: tb/test_pcm_gain_invert.sv
module test_pcm_gain_invert;
    localparam int NCH = 4;
    localparam int SW  = 24;
    localparam int DW  = NCH * SW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_ch = '0;
    logic [7:0]    cfg_vol = '0;
    logic          cfg_inv = 1'b0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          out_valid;
    logic [DW-1:0] out_data;
    logic [NCH-1:0] out_ovf;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    pcm_gain_invert #(.NCH(NCH), .SW(SW)) i_pcm_gain_invert (
        .clk (clk), .rst_n (rst_n), .cfg_we (cfg_we), .cfg_ch (cfg_ch),
        .cfg_vol (cfg_vol), .cfg_inv (cfg_inv), .in_valid (in_valid),
        .in_data (in_data), .out_valid (out_valid), .out_data (out_data),
        .out_ovf (out_ovf)
    );

    // {code[7:0], invert, sample[23:0]}
    localparam logic [32:0] VEC [16] = '{
        {8'h00, 1'b0, 24'h123456}, {8'hFF, 1'b0, 24'h400000},
        {8'hFE, 1'b0, 24'hF0BDC0}, {8'h30, 1'b0, 24'h001000},
        {8'h7F, 1'b0, 24'h001000}, {8'h45, 1'b0, 24'h001000},
        {8'h80, 1'b0, 24'h7FFFFF}, {8'h0C, 1'b0, 24'h300000},
        {8'h0C, 1'b0, 24'h500000}, {8'h18, 1'b0, 24'hC00000},
        {8'h00, 1'b1, 24'h123456}, {8'h00, 1'b1, 24'h800000},
        {8'h00, 1'b1, 24'h7FFFFF}, {8'h06, 1'b1, 24'h010000},
        {8'hE8, 1'b0, 24'h100000}, {8'h81, 1'b1, 24'hFFFFFF}
    };
    localparam string VREQ [16] = '{
        "R3", "R4", "R4", "R5", "R5", "R5", "R6", "R4",
        "R8", "R8", "R7", "R9", "R7", "R7", "R4", "R6"
    };

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic longint model(input logic [7:0] code, input bit inv,
                                     input logic [23:0] x24, output bit ovf);
        int h, q, r;
        longint m, p, v;
        h = int'($signed(code));
        if (h > 48) h = 48;
        q = (h >= 0) ? h / 12 : -((-h + 11) / 12);
        r = h - 12 * q;
        m = longint'($rtoi(65536.0 * (10.0 ** (r / 40.0)) + 0.5));
        p = longint'($signed(x24)) * m;
        v = p >>> (16 - q);
        if (inv) v = -v;
        ovf = 1'b0;
        if (v > 64'sd8388607)       begin v = 64'sd8388607;  ovf = 1'b1; end
        else if (v < -64'sd8388608) begin v = -64'sd8388608; ovf = 1'b1; end
        return v;
    endfunction

    function automatic longint lane(input int k);
        return longint'($signed(out_data[k*SW +: SW]));
    endfunction

    task automatic write_cfg(input int ch, input logic [7:0] vol, input bit inv);
        cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_vol = vol; cfg_inv = inv;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Drives one word at a negedge; returns at the negedge after the second edge.
    task automatic send(input logic [DW-1:0] word);
        in_valid = 1'b1; in_data = word;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        bit ovf_e;
        longint exp_y;
        repeat (3) @(negedge clk);
        chk("R1 reset out_valid", longint'(out_valid), 0);
        chk("R1 reset out_ovf", longint'(out_ovf), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1/R11: default settings pass each lane through unchanged
        send({24'h800000, 24'h7FFFFF, 24'hABCDEF, 24'h000123});
        chk("R2 out_valid high", longint'(out_valid), 1);
        chk("R1 R11 lane0", longint'(out_data[23:0]), 64'h000123);
        chk("R1 R11 lane1", longint'(out_data[47:24]), 64'hABCDEF);
        chk("R1 R11 lane2", longint'(out_data[71:48]), 64'h7FFFFF);
        chk("R1 R11 lane3", longint'(out_data[95:72]), 64'h800000);
        chk("R1 no ovf", longint'(out_ovf), 0);
        @(negedge clk);
        chk("R2 single-cycle valid", longint'(out_valid), 0);
        chk("R12 ovf idle", longint'(out_ovf), 0);

        // R2: exact latency
        in_valid = 1'b1; in_data = '0;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R2 not after one edge", longint'(out_valid), 0);
        @(negedge clk);
        chk("R2 after two edges", longint'(out_valid), 1);
        @(negedge clk);

        // Vector table walk, lane cycles through channels
        for (int i = 0; i < 16; i++) begin
            int ch;
            logic [DW-1:0] word;
            ch = i % NCH;
            write_cfg(ch, VEC[i][32:25], VEC[i][24]);
            word = '0;
            word[ch*SW +: SW] = VEC[i][23:0];
            send(word);
            exp_y = model(VEC[i][32:25], VEC[i][24], VEC[i][23:0], ovf_e);
            chk(VREQ[i], lane(ch), exp_y);
            chk("R8 ovf bit", longint'(out_ovf[ch]), longint'(ovf_e));
            chk("R11 other ovf bits", longint'(out_ovf & ~(4'b1 << ch)), 0);
            @(negedge clk);
            chk("R12 ovf after valid", longint'(out_ovf), 0);
        end

        // Directed values for key codes
        write_cfg(0, 8'h30, 1'b0);
        write_cfg(1, 8'h7F, 1'b0);
        write_cfg(2, 8'h00, 1'b1);
        write_cfg(3, 8'h0C, 1'b0);
        send({24'h500000, 24'h800000, 24'h001000, 24'h001000});
        chk("R5 +24dB x16", lane(0), 64'h10000);
        chk("R5 clamp 0x7F", lane(1), 64'h10000);
        chk("R9 invert min", lane(2), 64'h7FFFFF);
        chk("R8 positive rail", lane(3), 64'h7FFFFF);
        chk("R8 R9 ovf vector", longint'(out_ovf), 64'hC);

        // R10: a write to one channel leaves the rest alone
        for (int k = 0; k < NCH; k++) write_cfg(k, 8'h00, 1'b0);
        write_cfg(2, 8'h0C, 1'b1);
        send({4{24'h100000}});
        chk("R10 lane0 untouched", lane(0), 64'h100000);
        chk("R10 lane1 untouched", lane(1), 64'h100000);
        chk("R10 lane2 updated", lane(2), -64'sh200000);
        chk("R10 lane3 untouched", lane(3), 64'h100000);

        // R10: setting written in the same cycle as a sample applies only later
        cfg_we = 1'b1; cfg_ch = 2'd0; cfg_vol = 8'h0C; cfg_inv = 1'b0;
        in_valid = 1'b1; in_data = {4{24'h010000}};
        @(negedge clk);
        cfg_we = 1'b0;
        in_data = {4{24'h020000}};
        @(negedge clk);
        in_valid = 1'b0;
        chk("R10 old setting on same-cycle sample", lane(0), 64'h010000);
        @(negedge clk);
        chk("R10 new setting on next sample", lane(0), 64'h040000);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule